// File: doc/BRIEF.md
# Two-Step Comparator Offset Trim Sequencer

This block finds the digital trim settings that cancel the input-referred offset of a dynamic comparator. While it runs, both comparator inputs are tied to common mode. It must run before any capacitor-array calibration that depends on the comparator. The correction is split into two parts. The first is a coarse delay code for a timing-controlled charge-injection device, worth roughly 10 mV per step over four steps. The second is a 4-bit fine code for a binary-weighted injection array (x8, x4, x2, x1) fired at a fixed delay, worth roughly 1 mV per step. Correction charge goes to one side of the comparator only, so the block also chooses that side.

A one-cycle `start` pulse launches the sequence, and the block takes one comparator decision per clock. The first decision is taken with every correction off, and it fixes the side. The coarse code then climbs until the decision changes polarity. The coarse code then drops back one step, and the fine code climbs until the next polarity change. The whole sequence takes at most 20 decisions. The result stays on the outputs, with `done` high, until the next `start`.

Top module: `ofs_trim_seq`

## Requirements
- R1: After a synchronous reset, `side_sel`, `coarse_code` and `fine_code` are 0 and `done` is low.
- R2: A `start` pulse seen while idle or done clears both codes, the side select and `done` on the next clock edge. The first decision after that edge is taken with all corrections at zero.
- R3: The first decision sets `side_sel` to its inverse. `cmp_dec`=1 gives `side_sel`=0, and `cmp_dec`=0 gives `side_sel`=1. The side select then holds for the rest of the run.
- R4: In the coarse stage the coarse code starts at 1 and rises by one each cycle while the decision keeps its first polarity. On the first flip the code steps back by one. If no flip occurs, it stops at 4.
- R5: The fine stage starts only after the coarse stage ends, and the fine code stays 0 during the coarse stage.
- R6: The fine code starts at 1, rises by one each cycle while the polarity holds, and stops at the first flip, keeping the flipping value, or at 15.
- R7: `done` rises exactly 1 + (coarse decisions) + (fine decisions) cycles after the start edge, and never later than 20 cycles.
- R8: While `done` is high and `start` is low, all outputs hold their values.
- R9: A `start` pulse while a run is in progress has no effect on the result or on the run length.
- R10: The coarse code never exceeds 4 and the fine code never exceeds 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a trim run |
| cmp_dec | input | 1 | Comparator decision, 1 when the positive side wins |
| side_sel | output | 1 | Side that receives correction charge |
| coarse_code | output | 3 | Coarse delay setting, 0 to 4 |
| fine_code | output | 4 | Fine array setting, 0 to 15 |
| done | output | 1 | High once the trim result is valid |

## Verification
The assertions check the following on every cycle:
- neither code leaves its range;
- the fine code stays zero while the coarse search runs;
- the side select does not move after the first decision;
- an active run never lasts longer than 20 cycles;
- the outputs stay frozen while `done` is high.

Only the bench scenarios can show that the final codes sit at the first polarity change for a given offset. They also show the exact run length, and that a mid-run `start` leaves the result unchanged. For these checks a behavioural comparator, driven by the block's own outputs, is run over positive, negative, zero and out-of-range offsets.

// File: rtl/ofs_trim_pkg.sv
package ofs_trim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PROBE  = 3'd1,
    ST_COARSE = 3'd2,
    ST_FINE   = 3'd3,
    ST_DONE   = 3'd4
  } trim_state_t;
endpackage

// File: rtl/ofs_trim_polarity.sv
module ofs_trim_polarity (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic capture,
  input  logic dec,
  output logic flip,
  output logic side
);
  logic ref_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ref_q <= 1'b0;
      side  <= 1'b0;
    end else if (capture) begin
      ref_q <= dec;
      side  <= ~dec;
    end
  end

  assign flip = dec ^ ref_q;

  // R3: side changes only on a capture or a clear
  a_r3_side_hold: assert property (@(posedge clk) disable iff (rst)
    (!capture && !clear) |=> $stable(side));
endmodule

// File: rtl/ofs_trim_stage.sv
module ofs_trim_stage #(
  parameter int W   = 3,
  parameter int MAX = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load_one,
  input  logic         inc,
  input  logic         step_back,
  output logic [W-1:0] code,
  output logic         at_max
);
  localparam logic [W-1:0] MAXV = W'(MAX);
  localparam logic [W-1:0] ONEV = W'(1);

  always_ff @(posedge clk) begin
    if (rst || clear)
      code <= '0;
    else if (load_one)
      code <= ONEV;
    else if (step_back && code != '0)
      code <= code - ONEV;
    else if (inc && code != MAXV)
      code <= code + ONEV;
  end

  assign at_max = (code == MAXV);

  // R10: the code never leaves its range
  a_r10_code_range: assert property (@(posedge clk) disable iff (rst)
    code <= MAXV);
endmodule

// File: rtl/ofs_trim_ctrl.sv
module ofs_trim_ctrl
  import ofs_trim_pkg::*;
#(
  parameter int COARSE_STEPS = 4,
  parameter int FINE_BITS    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        flip,
  input  logic        coarse_max,
  input  logic        fine_max,
  output logic        clr,
  output logic        capture,
  output logic        c_inc,
  output logic        c_back,
  output logic        f_load,
  output logic        f_inc,
  output logic        done,
  output trim_state_t state
);
  localparam int LIMIT = 1 + COARSE_STEPS + (2**FINE_BITS) - 1;
  localparam int BCW   = $clog2(LIMIT + 2);

  trim_state_t state_d;

  always_comb begin
    state_d = state;
    clr     = 1'b0;
    capture = 1'b0;
    c_inc   = 1'b0;
    c_back  = 1'b0;
    f_load  = 1'b0;
    f_inc   = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          clr     = 1'b1;
          state_d = ST_PROBE;
        end
      end
      ST_PROBE: begin
        capture = 1'b1;
        c_inc   = 1'b1;
        state_d = ST_COARSE;
      end
      ST_COARSE: begin
        if (flip) begin
          c_back  = 1'b1;
          f_load  = 1'b1;
          state_d = ST_FINE;
        end else if (coarse_max) begin
          f_load  = 1'b1;
          state_d = ST_FINE;
        end else begin
          c_inc = 1'b1;
        end
      end
      ST_FINE: begin
        if (flip || fine_max)
          state_d = ST_DONE;
        else
          f_inc = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= (state_d == ST_DONE);
    end
  end

  // R7: run-length bound, counted independently of the transition logic
  logic [BCW-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)
      busy_cnt <= '0;
    else if (state == ST_PROBE || state == ST_COARSE || state == ST_FINE)
      busy_cnt <= busy_cnt + 1'b1;
    else
      busy_cnt <= '0;
  end

  a_r7_run_bound: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= BCW'(LIMIT));
endmodule

// File: rtl/ofs_trim_seq.sv
module ofs_trim_seq
  import ofs_trim_pkg::*;
#(
  parameter int COARSE_STEPS = 4,
  parameter int FINE_BITS    = 4,
  parameter int CW           = $clog2(COARSE_STEPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 cmp_dec,
  output logic                 side_sel,
  output logic [CW-1:0]        coarse_code,
  output logic [FINE_BITS-1:0] fine_code,
  output logic                 done
);
  localparam int FINE_MAX = (2**FINE_BITS) - 1;

  logic clr, capture, c_inc, c_back, f_load, f_inc;
  logic flip, coarse_max, fine_max;
  trim_state_t state;

  ofs_trim_ctrl #(.COARSE_STEPS(COARSE_STEPS), .FINE_BITS(FINE_BITS)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .flip(flip),
    .coarse_max(coarse_max), .fine_max(fine_max),
    .clr(clr), .capture(capture), .c_inc(c_inc), .c_back(c_back),
    .f_load(f_load), .f_inc(f_inc), .done(done), .state(state)
  );

  ofs_trim_polarity pol_i (
    .clk(clk), .rst(rst), .clear(clr), .capture(capture),
    .dec(cmp_dec), .flip(flip), .side(side_sel)
  );

  ofs_trim_stage #(.W(CW), .MAX(COARSE_STEPS)) coarse_i (
    .clk(clk), .rst(rst), .clear(clr), .load_one(1'b0),
    .inc(c_inc), .step_back(c_back), .code(coarse_code), .at_max(coarse_max)
  );

  ofs_trim_stage #(.W(FINE_BITS), .MAX(FINE_MAX)) fine_i (
    .clk(clk), .rst(rst), .clear(clr), .load_one(f_load),
    .inc(f_inc), .step_back(1'b0), .code(fine_code), .at_max(fine_max)
  );

  // R5: fine array untouched until the coarse search ends
  a_r5_fine_idle_in_coarse: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COARSE || state == ST_PROBE) |-> fine_code == '0);

  // R8: result frozen while done and no new request
  a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(coarse_code) && $stable(fine_code) && $stable(side_sel)));

  // R3: side fixed through both search stages
  a_r3_side_in_search: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COARSE || state == ST_FINE) |=> $stable(side_sel));
endmodule

// File: tb/ofs_trim_seq_tb_top.sv
module ofs_trim_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CSTEP = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmp_dec;
  logic side_sel;
  logic [2:0] coarse_code;
  logic [3:0] fine_code;
  logic done;

  int offset_mv = 0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofs_trim_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .cmp_dec(cmp_dec),
    .side_sel(side_sel), .coarse_code(coarse_code),
    .fine_code(fine_code), .done(done)
  );

  // behavioural comparator with injected correction
  always_comb begin
    int corr, eff;
    corr = int'(coarse_code) * CSTEP + int'(fine_code);
    eff  = side_sel ? offset_mv + corr : offset_mv - corr;
    cmp_dec = (eff > 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (offset %0d)", req, act, exp, offset_mv);
    end
  endtask

  function automatic int thresh(input int o);
    return (o > 0) ? o : 1 - o;
  endfunction

  function automatic int exp_nc(input int o);
    for (int k = 1; k <= 4; k++) if (k * CSTEP >= thresh(o)) return k;
    return 4;
  endfunction

  function automatic int exp_coarse(input int o);
    for (int k = 1; k <= 4; k++) if (k * CSTEP >= thresh(o)) return k - 1;
    return 4;
  endfunction

  function automatic int exp_fine(input int o);
    for (int f = 1; f <= 15; f++) if (exp_coarse(o) * CSTEP + f >= thresh(o)) return f;
    return 15;
  endfunction

  task automatic run_one(input int o, input bit poke);
    int n;
    bit hung;
    offset_mv = o;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 coarse cleared", int'(coarse_code), 0);
    chk("R2 fine cleared", int'(fine_code), 0);
    chk("R2 done low", int'(done), 0);
    n = 0;
    hung = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (n == 1) chk("R3 side", int'(side_sel), (o > 0) ? 0 : 1);
      if (n <= exp_nc(o)) chk("R5 fine idle", int'(fine_code), 0);
      if (poke && n == 3) start = 1'b1;
      else start = 1'b0;
      if (done) begin hung = 1'b0; break; end
    end
    start = 1'b0;
    if (hung) chk("R7 watchdog", 0, 1);
    chk("R7 run length", n, 1 + exp_nc(o) + exp_fine(o));
    chk("R4 coarse", int'(coarse_code), exp_coarse(o));
    chk("R6 fine", int'(fine_code), exp_fine(o));
    chk("R3 side final", int'(side_sel), (o > 0) ? 0 : 1);
    if (poke) chk("R9 busy start ignored", n, 1 + exp_nc(o) + exp_fine(o));
    repeat (3) @(negedge clk);
    chk("R8 done held", int'(done), 1);
    chk("R8 coarse held", int'(coarse_code), exp_coarse(o));
    chk("R8 fine held", int'(fine_code), exp_fine(o));
    chk("R10 coarse range", int'(coarse_code <= 3'd4), 1);
  endtask

  initial begin
    int dir [10] = '{0, 1, -1, 10, 11, 40, 45, 60, -55, -9};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 side", int'(side_sel), 0);
    chk("R1 coarse", int'(coarse_code), 0);
    chk("R1 fine", int'(fine_code), 0);
    chk("R1 done", int'(done), 0);
    foreach (dir[i]) run_one(dir[i], 1'b0);
    run_one(33, 1'b1);
    run_one(-17, 1'b1);
    for (int i = 0; i < 40; i++) run_one(int'($urandom_range(120)) - 60, i[2]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R7 global watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule